// File: doc/BRIEF.md
# ADC Conversion Sequencer with Limit Compare

This block controls when an analog-to-digital converter runs and decides whether each finished conversion is reported. The converter is modelled as a stub with a fixed latency. The sample value on `sample_in` is taken on the cycle a conversion finishes. A conversion can start in three ways: a software start carried by a control-register write, a hardware trigger pulse, or an automatic restart when continuous mode is on.

When compare is enabled, the block subtracts a programmable threshold from the sample. It then tests either an upper limit (sample at or above the threshold) or a lower limit (sample below the threshold). Only a passing test writes the difference into the result register and raises the done flag. A failing test leaves both untouched. With compare disabled, every conversion stores the raw sample and raises the flag. An interrupt follows the flag when interrupts are enabled, and it serves as the wake request in low-power wait.

Two low-power inputs steer the sequencer. In wait mode, a conversion already running is allowed to finish, and new conversions still start from the hardware trigger or from continuous mode. In stop mode without the asynchronous conversion clock, any running conversion is dropped and the sequencer returns to idle.

Top module: `adc_cmp_ctrl`

## Requirements
- R1: After reset, `busy`, `done_flag` and `irq` are 0 and `result` is 0.
- R2: A write (`ctl_wr`=1) with `ctl_start`=1 while idle sets `busy` on the next edge. The conversion completes LAT clock edges after that, on the edge where `sample_in` is captured. A start while busy is ignored.
- R3: With compare disabled, a completed conversion stores the raw sample in `result` and sets `done_flag`.
- R4: With compare enabled and the limit select `ctl_upper`=1, a sample greater than or equal to `cmp_val` sets `done_flag`. In that case `result` gets (sample − `cmp_val`) taken modulo 2^RES_W.
- R5: With compare enabled and `ctl_upper`=0, a sample strictly less than `cmp_val` sets `done_flag`. In that case `result` gets (sample − `cmp_val`) taken modulo 2^RES_W.
- R6: With compare enabled and the limit test false, `done_flag` is not set and `result` keeps its previous value.
- R7: A pulse on `res_rd` or a control write clears `done_flag`. If a passing completion falls on the same edge, the flag is set instead.
- R8: `irq` is 1 exactly when `done_flag` is 1 and the stored interrupt enable is 1.
- R9: In continuous mode, a new conversion starts on the same edge one ends, whatever the compare outcome, so `busy` stays 1.
- R10: While `wait_mode`=1, a running conversion completes normally. A software start is ignored, but `hw_trig` still starts a conversion.
- R11: While `stop_mode`=1 and the stored async-clock select is 0, a running conversion is aborted, `busy` falls on the next edge, `result` is kept, and no start is accepted. With the async-clock select at 1, conversions run normally in stop mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_start | input | 1 | Software start request carried by the write |
| ctl_cmp_en | input | 1 | Compare enable field |
| ctl_upper | input | 1 | Limit select: 1 upper (>=), 0 lower (<) |
| ctl_cont | input | 1 | Continuous conversion field |
| ctl_irq_en | input | 1 | Interrupt enable field |
| ctl_async | input | 1 | Asynchronous conversion clock select field |
| cmp_val | input | RES_W | Compare threshold |
| hw_trig | input | 1 | Hardware trigger pulse |
| res_rd | input | 1 | Result read strobe |
| wait_mode | input | 1 | Low-power wait indication |
| stop_mode | input | 1 | Low-power stop indication |
| sample_in | input | RES_W | Converter stub output, taken at completion |
| result | output | RES_W | Result register |
| done_flag | output | 1 | Conversion-complete flag |
| irq | output | 1 | Interrupt / wake request |
| busy | output | 1 | Conversion in progress |

## Verification
A wrong borrow or limit-select decision appears as a flag on the wrong side of the threshold, or as a stored value that is the raw sample instead of the difference. Either shows on `done_flag` and `result` at the completion edge, LAT cycles after the start. A miscounted latency shifts that edge by a cycle and is caught by sampling one cycle before and at completion. A missed stop abort leaves `busy` high one cycle after `stop_mode`, and a lost continuous restart drops `busy` right after the first completion.

// File: rtl/adc_cmp_ctrl.sv
module adc_cmp_ctrl #(
  parameter int RES_W = 12,
  parameter int LAT   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr,
  input  logic             ctl_start,
  input  logic             ctl_cmp_en,
  input  logic             ctl_upper,
  input  logic             ctl_cont,
  input  logic             ctl_irq_en,
  input  logic             ctl_async,
  input  logic [RES_W-1:0] cmp_val,
  input  logic             hw_trig,
  input  logic             res_rd,
  input  logic             wait_mode,
  input  logic             stop_mode,
  input  logic [RES_W-1:0] sample_in,
  output logic [RES_W-1:0] result,
  output logic             done_flag,
  output logic             irq,
  output logic             busy
);
  localparam int CW = $clog2(LAT + 1);
  localparam logic [CW-1:0] CNT_INIT = CW'(LAT - 1);

  logic          cmp_q, upper_q, cont_q, irqen_q, async_q;
  logic [CW-1:0] cnt;
  logic [RES_W:0] diff;

  wire stop_blk = stop_mode & ~async_q;
  wire sw_go    = ctl_wr & ctl_start & ~wait_mode;
  wire go       = (sw_go | hw_trig) & ~busy & ~stop_blk;
  wire done     = busy & (cnt == '0) & ~stop_blk;
  wire below    = diff[RES_W];
  wire hit      = ~cmp_q | (upper_q ? ~below : below);

  assign diff = {1'b0, sample_in} - {1'b0, cmp_val};
  assign irq  = done_flag & irqen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {cmp_q, upper_q, cont_q, irqen_q, async_q} <= '0;
    end else if (ctl_wr) begin
      {cmp_q, upper_q, cont_q, irqen_q, async_q} <=
        {ctl_cmp_en, ctl_upper, ctl_cont, ctl_irq_en, ctl_async};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (stop_blk) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (done) begin
      busy <= cont_q;
      cnt  <= CNT_INIT;
    end else if (go) begin
      busy <= 1'b1;
      cnt  <= CNT_INIT;
    end else if (busy) begin
      cnt  <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_flag <= 1'b0;
      result    <= '0;
    end else if (done && hit) begin
      done_flag <= 1'b1;
      result    <= cmp_q ? diff[RES_W-1:0] : sample_in;
    end else if (res_rd || ctl_wr) begin
      done_flag <= 1'b0;
    end
  end

  a_r2_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(go));
  a_r6_result_only_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> $stable(result));
  a_r6_fail_keeps_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !hit && !res_rd && !ctl_wr) |=> $stable(done_flag) && $stable(result));
  a_r7_flag_rise_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_flag) |-> $past(done));
  a_r9_cont_keeps_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cont_q) |=> busy);
  a_r11_stop_aborts: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_mode && !async_q) |=> !busy);
endmodule

// File: tb/tb_adc_cmp_ctrl.sv
module tb_adc_cmp_ctrl;
  localparam int RES_W = 12;
  localparam int LAT   = 8;
  localparam time TCLK = 10ns;

  logic clk = 0, rst_n = 0;
  logic ctl_wr = 0, ctl_start = 0, ctl_cmp_en = 0, ctl_upper = 0, ctl_cont = 0;
  logic ctl_irq_en = 0, ctl_async = 0, hw_trig = 0, res_rd = 0;
  logic wait_mode = 0, stop_mode = 0;
  logic [RES_W-1:0] cmp_val = '0, sample_in = '0, result;
  logic done_flag, irq, busy;
  int total = 0, bad = 0;

  always #(TCLK/2) clk = ~clk;

  adc_cmp_ctrl #(.RES_W(RES_W), .LAT(LAT)) dut (
    .clk, .rst_n, .ctl_wr, .ctl_start, .ctl_cmp_en, .ctl_upper, .ctl_cont,
    .ctl_irq_en, .ctl_async, .cmp_val, .hw_trig, .res_rd, .wait_mode,
    .stop_mode, .sample_in, .result, .done_flag, .irq, .busy);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(bit start, bit cen, bit up, bit cont, bit ien, bit asy);
    ctl_wr = 1; ctl_start = start; ctl_cmp_en = cen; ctl_upper = up;
    ctl_cont = cont; ctl_irq_en = ien; ctl_async = asy;
    @(negedge clk);
    ctl_wr = 0; ctl_start = 0;
  endtask

  task automatic t_reset;
    chk("R1 busy", busy, 0); chk("R1 flag", done_flag, 0);
    chk("R1 irq", irq, 0);   chk("R1 result", result, 0);
  endtask

  task automatic t_raw;
    sample_in = 12'h5A3;
    wr(1, 0, 0, 0, 1, 0);
    chk("R2 busy after start", busy, 1);
    repeat (LAT - 1) @(negedge clk);
    chk("R2 not done early", done_flag, 0);
    @(negedge clk);
    chk("R3 raw result", result, 12'h5A3);
    chk("R3 flag", done_flag, 1);
    chk("R8 irq", irq, 1);
    chk("R2 idle after", busy, 0);
  endtask

  task automatic t_upper;
    cmp_val = 12'h300; sample_in = 12'h345;
    wr(1, 1, 1, 0, 0, 0);
    chk("R7 write clears flag", done_flag, 0);
    repeat (LAT) @(negedge clk);
    chk("R4 flag", done_flag, 1);
    chk("R4 diff", result, 12'h045);
    chk("R8 irq off", irq, 0);
    res_rd = 1; @(negedge clk); res_rd = 0;
    chk("R7 read clears", done_flag, 0);
    sample_in = 12'h300;
    wr(1, 1, 1, 0, 1, 0);
    repeat (LAT) @(negedge clk);
    chk("R4 equal passes", done_flag, 1);
    chk("R4 equal diff", result, 12'h000);
  endtask

  task automatic t_lower;
    cmp_val = 12'h100; sample_in = 12'h0F0;
    wr(1, 1, 0, 0, 1, 0);
    repeat (LAT) @(negedge clk);
    chk("R5 flag", done_flag, 1);
    chk("R5 wrapped diff", result, 12'hFF0);
    sample_in = 12'h100;
    wr(1, 1, 0, 0, 1, 0);
    repeat (LAT) @(negedge clk);
    chk("R6 equal fails lower", done_flag, 0);
    chk("R6 result kept", result, 12'hFF0);
    chk("R8 irq low", irq, 0);
    sample_in = 12'h0FF; cmp_val = 12'h100;
    wr(1, 1, 1, 0, 1, 0);
    repeat (LAT) @(negedge clk);
    chk("R6 upper fail flag", done_flag, 0);
    chk("R6 upper fail result", result, 12'hFF0);
  endtask

  task automatic t_same_edge;
    sample_in = 12'h222;
    wr(1, 0, 0, 0, 1, 0);
    repeat (LAT - 1) @(negedge clk);
    res_rd = 1; @(negedge clk); res_rd = 0;
    chk("R7 set wins over read", done_flag, 1);
    chk("R7 result", result, 12'h222);
  endtask

  task automatic t_cont;
    cmp_val = 12'h800; sample_in = 12'h100;
    wr(1, 1, 1, 1, 1, 0);
    repeat (LAT) @(negedge clk);
    chk("R9 busy after fail", busy, 1);
    chk("R9 no flag", done_flag, 0);
    sample_in = 12'h900;
    repeat (LAT) @(negedge clk);
    chk("R9 second conv flag", done_flag, 1);
    chk("R9 second conv diff", result, 12'h100);
    chk("R9 still busy", busy, 1);
    wr(0, 0, 0, 0, 0, 0);
    repeat (LAT + 1) @(negedge clk);
    chk("R9 stops when cleared", busy, 0);
  endtask

  task automatic t_wait;
    sample_in = 12'h0AB;
    wr(1, 0, 0, 0, 1, 0);
    repeat (3) @(negedge clk);
    wait_mode = 1;
    repeat (LAT - 3) @(negedge clk);
    chk("R10 completes in wait", result, 12'h0AB);
    chk("R10 irq wake", irq, 1);
    wr(1, 0, 0, 0, 1, 0);
    chk("R10 sw start ignored", busy, 0);
    sample_in = 12'h0CD;
    hw_trig = 1; @(negedge clk); hw_trig = 0;
    chk("R10 hw trig starts", busy, 1);
    repeat (LAT) @(negedge clk);
    chk("R10 hw result", result, 12'h0CD);
    wait_mode = 0;
  endtask

  task automatic t_stop;
    sample_in = 12'h777;
    wr(1, 0, 0, 0, 1, 0);
    repeat (3) @(negedge clk);
    stop_mode = 1; @(negedge clk);
    chk("R11 aborted", busy, 0);
    hw_trig = 1; @(negedge clk); hw_trig = 0;
    chk("R11 no start in stop", busy, 0);
    repeat (LAT + 2) @(negedge clk);
    chk("R11 result kept", result, 12'h0CD);
    chk("R11 no flag", done_flag, 0);
    stop_mode = 0;
    wr(1, 0, 0, 0, 1, 1);
    stop_mode = 1;
    repeat (LAT) @(negedge clk);
    chk("R11 async runs in stop", result, 12'h777);
    chk("R11 async flag", done_flag, 1);
    stop_mode = 0;
  endtask

  initial begin
    repeat (2) @(negedge clk);
    t_reset;
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_raw; t_upper; t_lower; t_same_edge; t_cont; t_wait; t_stop;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule